// File: doc/BRIEF.md
# Serial Converter Host Controller

This block is the host side of a link to an 8-bit serial successive-approximation converter whose input multiplexer has one, two, four or eight inputs. A one-cycle start request makes the block pull an active-low chip select, run a serial clock divided down from the system clock, send a start bit and a channel address on the converter's data input, and then shift in the conversion result, most significant bit first, from the converter's data output.

When the echo option is on, the block keeps the serial clock running for seven more periods after the result. In those periods the converter sends the same byte again, least significant bit first, with the LSB shared between the two copies. The block reverses the echo and compares it with the first copy, and it reports any difference on a mismatch flag that is valid together with the result.

The channel count parameter sets the address length. The mode bit, single-ended or differential, and the channel or pair polarity are carried inside the address. The divider is derived from the system clock and target serial clock parameters, and an elaboration check rejects a serial clock outside 10 kHz to 400 kHz.

Top module: `sadc_host`

## Requirements
- R1: After reset, conv_cs_n is 1, conv_sclk is 0, busy is 0 and done is 0.
- R2: With eight channels, the bits sent on conv_sdi and taken at rising edges 1 to 5 are, in order: 1 (start), NOT diff_mode, ch_sel[0], ch_sel[2], ch_sel[1]. With four channels the last bit is dropped and with two channels the last two are dropped. With one channel no address is sent.
- R3: conv_sdi changes only in the cycle in which conv_sclk falls, or in which conv_cs_n falls. It is never changed while conv_sclk is high.
- R4: Every high phase and every low phase of conv_sclk lasts exactly HALF system cycles, where HALF = CLK_HZ / (2*SCLK_HZ). The first rising edge comes HALF cycles after conv_cs_n falls. conv_sclk is low whenever conv_cs_n is high.
- R5: With A address bits, conv_sdo is sampled at rising edges A+2 to A+9, and the first sample is the result MSB.
- R6: With the echo option on, conv_sdo at rising edges A+10 to A+16 carries result bits 1 to 7 in that order. mismatch is 1 when any of them differs from the first copy, and 0 otherwise.
- R7: A transaction has exactly A+9 rising edges, or A+16 with the echo option. conv_cs_n rises in the same cycle as the last falling edge. done is a one-cycle pulse in that cycle, and result and mismatch are valid from that cycle on.
- R8: conv_cs_n stays high for at least 2*HALF system cycles between two transactions. busy stays 1 during that time.
- R9: A start request while busy is 1 is ignored. No extra transaction follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle conversion request |
| ch_sel | input | CHW | Channel, or pair index with polarity in bit 0 |
| diff_mode | input | 1 | 1 = differential pair, 0 = single-ended |
| busy | output | 1 | Transaction or chip-select gap in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| result | output | DW | Converted byte, MSB-first copy |
| mismatch | output | 1 | Echo copy disagrees with the first copy |
| conv_cs_n | output | 1 | Active-low chip select to the converter |
| conv_sclk | output | 1 | Serial clock to the converter |
| conv_sdi | output | 1 | Address data to the converter |
| conv_sdo | input | 1 | Result data from the converter |

## Verification
Conversions run on single-ended channels with both odd and even indices, and on differential pairs with both polarities. A wrong select-bit order or an inverted mode bit therefore shows in the captured address. The result bytes include all zeros, all ones, a lone MSB, a lone LSB and alternating patterns, so a shift in direction or an off-by-one sample edge gives a different byte. The echo is corrupted at its first bit and at its last bit to show that the mismatch flag covers both ends. A start pulse during a transfer and another during the chip-select gap must leave the transfer count unchanged.

// File: rtl/sadc_pkg.sv
`timescale 1ns/1ps
package sadc_pkg;

    localparam int unsigned FRAME_MAX = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_GAP  = 2'd2
    } sadc_state_e;

    function automatic int unsigned addr_len(input int unsigned n_ch);
        if (n_ch == 8)      return 5;
        else if (n_ch == 4) return 4;
        else if (n_ch == 2) return 3;
        else                return 0;
    endfunction

endpackage

// File: rtl/sadc_sclk_gen.sv
`timescale 1ns/1ps
module sadc_sclk_gen #(
    parameter int unsigned HALF = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (HALF > 2) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == CW'(HALF - 1)) begin
            cnt_d = '0;
            tick  = 1'b1;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4: ticks are never adjacent, so each phase is at least two cycles
    p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/sadc_addr_frame.sv
`timescale 1ns/1ps
module sadc_addr_frame #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned CHW    = 3
) (
    input  logic [CHW-1:0]                 ch,
    input  logic                           diff,
    output logic [sadc_pkg::FRAME_MAX-1:0] frame
);
    // frame[0] is sent first
    generate
        if (NUM_CH == 8) begin : g_eight
            assign frame = {ch[1], ch[2], ch[0], ~diff, 1'b1};
        end else if (NUM_CH == 4) begin : g_four
            assign frame = {1'b0, ch[1], ch[0], ~diff, 1'b1};
        end else if (NUM_CH == 2) begin : g_two
            assign frame = {2'b00, ch[0], ~diff, 1'b1};
        end else begin : g_one
            assign frame = '0;
        end
    endgenerate

endmodule

// File: rtl/sadc_echo_cmp.sv
`timescale 1ns/1ps
module sadc_echo_cmp #(
    parameter int unsigned DW = 8
) (
    input  logic [DW-1:0] main_byte,
    input  logic [DW-2:0] echo_bits,
    output logic          differs
);
    // echo_bits[DW-2] arrived first and carries bit 1 of the byte
    logic [DW-2:0] bit_bad;

    generate
        for (genvar i = 0; i < DW - 1; i++) begin : g_rev
            assign bit_bad[i] = echo_bits[DW-2-i] ^ main_byte[i+1];
        end
    endgenerate

    assign differs = |bit_bad;

endmodule

// File: rtl/sadc_host.sv
`timescale 1ns/1ps
module sadc_host #(
    parameter int unsigned CLK_HZ  = 200_000_000,
    parameter int unsigned SCLK_HZ = 250_000,
    parameter int unsigned NUM_CH  = 8,
    parameter int unsigned ECHO_EN = 1,
    parameter int unsigned DW      = 8,
    parameter int unsigned CHW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [CHW-1:0] ch_sel,
    input  logic           diff_mode,
    output logic           busy,
    output logic           done,
    output logic [DW-1:0]  result,
    output logic           mismatch,
    output logic           conv_cs_n,
    output logic           conv_sclk,
    output logic           conv_sdi,
    input  logic           conv_sdo
);
    import sadc_pkg::*;

    localparam int unsigned HALF     = CLK_HZ / (2 * SCLK_HZ);
    localparam int unsigned REAL_HZ  = CLK_HZ / (2 * HALF);
    localparam int unsigned AL       = addr_len(NUM_CH);
    localparam int unsigned FIRST_D  = AL + 2;
    localparam int unsigned LAST_D   = AL + 1 + DW;
    localparam bit          HAS_ECHO = (ECHO_EN != 0);
    localparam int unsigned TOTAL    = LAST_D + (HAS_ECHO ? DW - 1 : 0);
    localparam int unsigned GAP_CYC  = 2 * HALF;
    localparam int unsigned NW       = $clog2(TOTAL + 1);
    localparam int unsigned GW       = $clog2(GAP_CYC + 1);
    localparam bit          HAS_ADDR = (AL > 0);

    generate
        if (HALF < 2 || REAL_HZ < 10_000 || REAL_HZ > 400_000) begin : g_bad_clk
            $error("sadc_host: serial clock outside the legal range");
        end
        if (NUM_CH != 1 && NUM_CH != 2 && NUM_CH != 4 && NUM_CH != 8) begin : g_bad_ch
            $error("sadc_host: channel count must be 1, 2, 4 or 8");
        end
    endgenerate

    typedef struct packed {
        sadc_state_e   st;
        logic          cs_n;
        logic          sclk;
        logic          sdi;
        logic [NW-1:0] nrise;
        logic [DW-1:0] res;
        logic [DW-2:0] echo;
        logic [DW-1:0] res_out;
        logic          mism;
        logic          done;
        logic [GW-1:0] gap;
    } host_t;

    localparam host_t RST_VAL = '{
        st: ST_IDLE, cs_n: 1'b1, sclk: 1'b0, sdi: 1'b0, nrise: '0,
        res: '0, echo: '0, res_out: '0, mism: 1'b0, done: 1'b0, gap: '0
    };

    host_t d, q;

    logic                 tick;
    logic [FRAME_MAX-1:0] frame;
    logic                 echo_differs;
    logic                 next_bit;
    logic                 first_bit;

    sadc_sclk_gen #(.HALF(HALF)) u_sclk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.st == ST_RUN),
        .tick  (tick)
    );

    sadc_addr_frame #(.NUM_CH(NUM_CH), .CHW(CHW)) u_frame (
        .ch    (ch_sel),
        .diff  (diff_mode),
        .frame (frame)
    );

    sadc_echo_cmp #(.DW(DW)) u_cmp (
        .main_byte (q.res),
        .echo_bits (q.echo),
        .differs   (echo_differs)
    );

    // Address bit for the rise after the one just counted
    always_comb begin
        next_bit  = 1'b0;
        first_bit = HAS_ADDR & frame[0];
        for (int i = 0; i < FRAME_MAX; i++) begin
            if (i < AL && q.nrise == NW'(i)) next_bit = frame[i];
        end
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st    = ST_RUN;
                    d.cs_n  = 1'b0;
                    d.sclk  = 1'b0;
                    d.nrise = '0;
                    d.sdi   = first_bit;
                    d.res   = '0;
                    d.echo  = '0;
                end
            end
            ST_RUN: begin
                if (tick) begin
                    if (!q.sclk) begin
                        d.sclk  = 1'b1;
                        d.nrise = q.nrise + 1'b1;
                        if (d.nrise >= NW'(FIRST_D) && d.nrise <= NW'(LAST_D)) begin
                            d.res = {q.res[DW-2:0], conv_sdo};
                        end else if (d.nrise > NW'(LAST_D)) begin
                            d.echo = {q.echo[DW-3:0], conv_sdo};
                        end
                    end else begin
                        d.sclk = 1'b0;
                        if (q.nrise == NW'(TOTAL)) begin
                            d.st      = ST_GAP;
                            d.cs_n    = 1'b1;
                            d.sdi     = 1'b0;
                            d.gap     = '0;
                            d.done    = 1'b1;
                            d.res_out = q.res;
                            d.mism    = HAS_ECHO & echo_differs;
                        end else begin
                            d.sdi = next_bit;
                        end
                    end
                end
            end
            ST_GAP: begin
                d.gap = q.gap + 1'b1;
                if (q.gap == GW'(GAP_CYC - 1)) d.st = ST_IDLE;
            end
            default: d = RST_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d;
    end

    assign busy      = (q.st != ST_IDLE);
    assign done      = q.done;
    assign result    = q.res_out;
    assign mismatch  = q.mism;
    assign conv_cs_n = q.cs_n;
    assign conv_sclk = q.sclk;
    assign conv_sdi  = q.sdi;

    // Cycles with chip select high, saturating; starts full after reset
    logic [GW:0] hi_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         hi_cnt_q <= (GW+1)'(GAP_CYC);
        else if (!q.cs_n)                   hi_cnt_q <= '0;
        else if (hi_cnt_q < (GW+1)'(GAP_CYC)) hi_cnt_q <= hi_cnt_q + 1'b1;
    end

    p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_cs_n |-> !conv_sclk);

    p_sclk_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(conv_sclk) |-> $past(tick));

    p_sdi_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(conv_sdi) |-> ($fell(conv_sclk) || $fell(conv_cs_n)));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (conv_cs_n && busy));

    p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_cs_n) |-> ($past(hi_cnt_q) >= (GW+1)'(GAP_CYC)));

    p_gap_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && q.st == ST_GAP) |=> conv_cs_n);

endmodule

// File: tb/sadc_host_tb.sv
`timescale 1ns/1ps
module sadc_host_tb_top;

    localparam int  HALF    = 16;
    localparam int  AL      = 5;
    localparam int  TOTAL   = AL + 1 + 8 + 7;
    localparam real CLK_NS  = 5.0;
    localparam real HALF_NS = HALF * CLK_NS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] ch_sel = '0;
    logic       diff_mode = 1'b0;
    logic       busy, done, mismatch;
    logic [7:0] result;
    logic       conv_cs_n, conv_sclk, conv_sdi;
    logic       conv_sdo = 1'b0;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    sadc_host #(
        .CLK_HZ(8_000_000), .SCLK_HZ(250_000), .NUM_CH(8), .ECHO_EN(1)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .ch_sel(ch_sel),
        .diff_mode(diff_mode), .busy(busy), .done(done), .result(result),
        .mismatch(mismatch), .conv_cs_n(conv_cs_n), .conv_sclk(conv_sclk),
        .conv_sdi(conv_sdi), .conv_sdo(conv_sdo)
    );

    // Converter model
    logic [7:0] m_data = '0;
    bit         m_corrupt = 1'b0;
    int         m_cbit = 0;
    int         m_nrise = 0;
    logic [4:0] m_addr = '0;
    int         sdi_viol = 0;
    int         width_err = 0;
    real        t_edge = 0.0;
    real        t_fall = 0.0;
    real        t_csrise = -1.0;
    real        last_gap = -1.0;

    always @(negedge conv_cs_n or posedge conv_sclk) begin
        if (conv_sclk) begin
            m_nrise = m_nrise + 1;
            if (m_nrise <= AL) m_addr = {m_addr[3:0], conv_sdi};
        end else begin
            m_nrise = 0;
            m_addr  = '0;
        end
    end

    always @(negedge conv_sclk) begin
        int idx;
        t_fall = $realtime;
        if (!conv_cs_n || t_fall > 0.0) begin
            idx = m_nrise + 1 - (AL + 2);
            if (idx >= 0 && idx < 8) conv_sdo <= m_data[7-idx];
            else if (idx >= 8 && idx < 15)
                conv_sdo <= m_data[idx-7] ^ (m_corrupt && (idx - 7 == m_cbit));
            else conv_sdo <= 1'b0;
        end
    end

    always @(conv_sdi) if (!conv_cs_n && conv_sclk) sdi_viol++;

    always @(conv_sclk) begin
        if (t_edge >= 0.0 && (($realtime - t_edge) > HALF_NS + 0.01 ||
                              ($realtime - t_edge) < HALF_NS - 0.01))
            width_err++;
        t_edge = $realtime;
    end

    always @(negedge conv_cs_n) begin
        t_edge = $realtime;
        if (t_csrise >= 0.0) last_gap = $realtime - t_csrise;
    end

    always @(posedge conv_cs_n) t_csrise = $realtime;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    task automatic conv_check(input logic [2:0] ch, input bit diff,
                              input logic [7:0] val, input bit corrupt, input int cbit);
        logic [4:0] exp_addr;
        int v0, w0;
        v0 = sdi_viol;
        w0 = width_err;
        m_data    = val;
        m_corrupt = corrupt;
        m_cbit    = cbit;
        ch_sel    = ch;
        diff_mode = diff;
        exp_addr  = {1'b1, ~diff, ch[0], ch[2], ch[1]};
        pulse_start();
        wait_done();
        chk(m_addr == exp_addr, "R2", "address frame", m_addr, exp_addr);
        chk(result == val, "R5", "result byte", result, val);
        chk(mismatch == corrupt, "R6", "mismatch flag", mismatch, corrupt);
        chk(m_nrise == TOTAL, "R7", "rising edge count", m_nrise, TOTAL);
        chk(conv_cs_n == 1'b1, "R7", "cs high with done", conv_cs_n, 1);
        chk(t_csrise == t_fall, "R7", "cs rise on last fall", int'(t_csrise), int'(t_fall));
        chk(sdi_viol == v0, "R3", "sdi changed while sclk high", sdi_viol - v0, 0);
        chk(width_err == w0, "R4", "sclk phase width errors", width_err - w0, 0);
        @(negedge clk);
        chk(done == 1'b0, "R7", "done one cycle", done, 0);
        chk(result == val, "R7", "result held", result, val);
        do @(negedge clk); while (busy);
    endtask

    task automatic test_reset();
        chk(conv_cs_n == 1'b1, "R1", "cs after reset", conv_cs_n, 1);
        chk(conv_sclk == 1'b0, "R1", "sclk after reset", conv_sclk, 0);
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(done == 1'b0, "R1", "done after reset", done, 0);
    endtask

    task automatic test_single_ended();
        conv_check(3'd0, 1'b0, 8'hA5, 1'b0, 0);
        conv_check(3'd5, 1'b0, 8'h3C, 1'b0, 0);
        conv_check(3'd6, 1'b0, 8'h80, 1'b0, 0);
    endtask

    task automatic test_differential();
        conv_check(3'd3, 1'b1, 8'hFF, 1'b0, 0);
        conv_check(3'd6, 1'b1, 8'h00, 1'b0, 0);
        conv_check(3'd1, 1'b1, 8'h01, 1'b0, 0);
    endtask

    task automatic test_echo_mismatch();
        conv_check(3'd2, 1'b0, 8'h5A, 1'b1, 1);
        conv_check(3'd7, 1'b0, 8'hC3, 1'b1, 7);
    endtask

    task automatic test_gap();
        conv_check(3'd4, 1'b0, 8'h69, 1'b0, 0);
        chk(conv_cs_n == 1'b1 && conv_sclk == 1'b0, "R4", "idle sclk low",
            conv_sclk, 0);
        conv_check(3'd4, 1'b0, 8'h96, 1'b0, 0);
        chk(last_gap >= 2.0 * HALF_NS - 0.01, "R8", "cs high gap ns",
            int'(last_gap), int'(2.0 * HALF_NS));
    endtask

    task automatic test_ignored_start();
        m_data = 8'h4E;
        m_corrupt = 1'b0;
        ch_sel = 3'd2;
        diff_mode = 1'b0;
        pulse_start();
        repeat (100) @(negedge clk);
        pulse_start();
        wait_done();
        chk(m_nrise == TOTAL, "R9", "edges with start while running", m_nrise, TOTAL);
        chk(result == 8'h4E, "R9", "result with start while running", result, 8'h4E);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R8", "busy in gap", busy, 1);
        repeat (4 * HALF) @(negedge clk);
        chk(conv_cs_n == 1'b1, "R9", "no transfer from gap start", conv_cs_n, 1);
        chk(busy == 1'b0, "R9", "idle after gap start", busy, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_single_ended();
        test_differential();
        test_echo_mismatch();
        test_gap();
        test_ignored_start();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule